// File: doc/BRIEF.md
# Vectorised Branch Condition Evaluator

This block decides whether a vectorised conditional branch is taken. A start pulse launches a walk over up to `MAXVL` elements. One element is handled per clock. For each element the block reads a 4-bit field from an internal 128-entry condition-field file, tests one bit of that field against an expected value, and may copy the field to a per-element destination. The walk halts early as soon as the outcome is fixed. It also halts where the predicate mask has a hole, and in that case the vector length is cut to that element. The block then reports the outcome, the effective vector length and a one-cycle `done` pulse.

A second mode handles a single element. The element index comes from the caller's step position, and the block returns the length that position implies. A step-mode flag makes the block take its field bits from an outside stepping unit instead of the file, and emit step-advance strobes to that unit. The field file has a load port and a combinational peek port, which the surrounding logic uses while the block is idle.

The sequencer has four states:

- `ST_IDLE` waits for `start`.
  - `start` with `vert_first` set moves to `ST_VSTEP`.
  - `start` with a zero length moves to `ST_DONE`.
  - Any other `start` moves to `ST_HRUN`.
- `ST_HRUN` handles one element per cycle. It moves to `ST_DONE` on any of:
  - a predicate hole,
  - an early-exit hit,
  - the last element.
- `ST_VSTEP` handles one element and always moves to `ST_DONE`.
- `ST_DONE` raises `done` and always returns to `ST_IDLE`.

Top module: `vbrcond_eval`

## Requirements
- R1: The record flag is sampled at `start` from `instr_word`. When `lr_form`=0 it is bit 30; when `lr_form`=1 it is bit 16. The other of those two bits is ignored.
- R2: The running result starts at the inverse of `all_mode`. A horizontal start with `vec_len`=0 gives `done` in the first cycle after the start edge, with `taken` equal to that initial value, `vl_out`=0 and no field writes.
- R3: Element k reads field number (`bit_sel[8:2]` + k) mod 128 and tests bit `bit_sel[1:0]` of it. The element condition is true when that bit equals `expect_val`.
- R4: In ALL mode (`all_mode`=1) the walk stops after the first false element. In ANY mode it stops after the first true element. `taken` is the condition of the last evaluated element. Without truncation `vl_out` equals `vec_len`.
- R5: If `pred_mask[k]`=0 when element k is reached, the walk stops without evaluating it. `vl_out`=k and `taken` keeps its previous value.
- R6: With the record flag set, each evaluated element k writes its 4 tested bits to field k. With it clear, the file is unchanged.
- R7: One element is handled per clock. `done` is high for exactly one cycle, n+1 cycles after the start edge, where n is the number of elements visited (including a predicate-hole element).
- R8: In vertical-first mode only element `src_step` is handled, and `done` follows 2 cycles after start. If its predicate bit is 1, it is evaluated and `vl_out`=`src_step`+1. Otherwise `taken` keeps the initial value and `vl_out`=`src_step`.
- R9: With `step_mode`=1 the tested bits come from `step_bits`, not the file. `step_we` pulses once per evaluated element in the horizontal walk, and once in vertical-first mode whatever the predicate. `step_val` is the element index plus 1.
- R10: `ld_we` writes `ld_data` to field `ld_idx` only while `busy`=0, and is ignored while busy. `pk_data` is field `pk_idx` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted in `ST_IDLE` |
| vec_len | input | VLW (5) | Vector length, 0..MAXVL |
| pred_mask | input | MAXVL (16) | Per-element predicate bits |
| bit_sel | input | AW+2 (9) | Source field base [8:2] and tested bit [1:0] |
| expect_val | input | 1 | Bit value that makes an element true |
| all_mode | input | 1 | 1 = ALL reduction, 0 = ANY reduction |
| instr_word | input | 32 | Branch instruction word holding the record flag |
| lr_form | input | 1 | Selects which bit of `instr_word` is the record flag |
| vert_first | input | 1 | Single-element mode |
| step_mode | input | 1 | Use `step_bits` and emit step strobes |
| step_bits | input | FW (4) | Field bits supplied by the stepping unit |
| src_step | input | EW (4) | Element index for single-element mode |
| ld_we | input | 1 | Field load strobe |
| ld_idx | input | AW (7) | Field load index |
| ld_data | input | FW (4) | Field load data |
| pk_idx | input | AW (7) | Field peek index |
| pk_data | output | FW (4) | Field peek data |
| busy | output | 1 | High outside `ST_IDLE` |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch outcome, held until the next start |
| vl_out | output | VLW (5) | Effective vector length, held until the next start |
| step_we | output | 1 | Step-advance strobe |
| step_val | output | VLW (5) | New step position carried by `step_we` |

## Verification
In the horizontal walk, a predicate hole and an early-exit hit compete for the same element slot. The hole must win, leaving the element unevaluated and unwritten. Sweeps over predicate masks with a single zero, combined with field patterns that make the same element decide the outcome, provoke this overlap. The bench judges it from `vl_out`, `taken`, the done latency and a full peek of the field file against an arithmetic model.

A field write-back and the next element's read can also touch the same entry in consecutive cycles. Base field 0 and wrap-around bases provoke this, and the model applies the writes in element order.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HRUN,
        ST_VSTEP,
        ST_DONE
    } vbr_state_e;

    typedef struct packed {
        logic all_mode;
        logic rec;
        logic expect_v;
        logic vf;
        logic step_mode;
    } vbr_cfg_t;

endpackage

// File: rtl/vbr_cf_file.sv
module vbr_cf_file #(
    parameter int FIELDS = 128,
    parameter int FW     = 4,
    localparam int AW    = $clog2(FIELDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [FW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [FW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [FW-1:0] pdata
);

    logic [FW-1:0] mem_q [FIELDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FIELDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
    assign pdata = mem_q[paddr];

endmodule

// File: rtl/vbr_elem_test.sv
module vbr_elem_test #(
    parameter int FW = 4,
    localparam int SW = $clog2(FW)
) (
    input  logic [FW-1:0] bits,
    input  logic [SW-1:0] sel,
    input  logic          expect_v,
    input  logic          all_mode,
    output logic          el_ok,
    output logic          stop_hit
);

    always_comb begin
        el_ok    = (bits[sel] == expect_v);
        stop_hit = all_mode ? !el_ok : el_ok;
    end

endmodule

// File: rtl/vbr_seq.sv
module vbr_seq
    import vbr_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int AW    = 7,
    localparam int EW   = $clog2(MAXVL),
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vec_len,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic [AW-1:0]    base_field,
    input  logic [EW-1:0]    src_step,
    input  vbr_cfg_t         cfg_in,
    input  logic             el_ok,
    input  logic             stop_hit,
    output vbr_cfg_t         cfg_o,
    output logic [AW-1:0]    rd_field,
    output logic             eng_we,
    output logic [AW-1:0]    eng_waddr,
    output logic             busy,
    output logic             done,
    output logic             taken,
    output logic [VLW-1:0]   vl_out,
    output logic             step_we,
    output logic [VLW-1:0]   step_val
);

    vbr_state_e       state_q, state_d;
    vbr_cfg_t         cfg_q;
    logic [EW-1:0]    elem_q;
    logic [VLW-1:0]   vl_q;
    logic [MAXVL-1:0] pred_q;
    logic [AW-1:0]    base_q;
    logic             res_q;
    logic [VLW-1:0]   vlout_q;

    logic             act;
    logic             last_el;
    logic [VLW-1:0]   elem_w;

    assign elem_w  = VLW'(elem_q);
    assign act     = pred_q[elem_q];
    assign last_el = (elem_w == vl_q - VLW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_in.vf)          state_d = ST_VSTEP;
                    else if (vec_len == '0) state_d = ST_DONE;
                    else                    state_d = ST_HRUN;
                end
            end
            ST_HRUN: begin
                if (!act || stop_hit || last_el) state_d = ST_DONE;
            end
            ST_VSTEP: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            elem_q  <= '0;
            vl_q    <= '0;
            pred_q  <= '0;
            base_q  <= '0;
            res_q   <= 1'b0;
            vlout_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        vl_q    <= vec_len;
                        pred_q  <= pred_mask;
                        base_q  <= base_field;
                        res_q   <= !cfg_in.all_mode;
                        vlout_q <= cfg_in.vf ? '0 : vec_len;
                        elem_q  <= cfg_in.vf ? src_step : '0;
                    end
                end
                ST_HRUN: begin
                    if (!act) begin
                        vlout_q <= elem_w;
                    end else begin
                        res_q <= el_ok;
                        if (!stop_hit && !last_el) elem_q <= elem_q + EW'(1);
                    end
                end
                ST_VSTEP: begin
                    if (act) begin
                        res_q   <= el_ok;
                        vlout_q <= elem_w + VLW'(1);
                    end else begin
                        vlout_q <= elem_w;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cfg_o     = cfg_q;
        rd_field  = base_q + AW'(elem_q);
        eng_waddr = AW'(elem_q);
        eng_we    = 1'b0;
        step_we   = 1'b0;
        step_val  = elem_w + VLW'(1);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        taken     = res_q;
        vl_out    = vlout_q;
        unique case (state_q)
            ST_HRUN: begin
                eng_we  = act && cfg_q.rec;
                step_we = act && cfg_q.step_mode;
            end
            ST_VSTEP: begin
                eng_we  = act && cfg_q.rec;
                step_we = cfg_q.step_mode;
            end
            default: ;
        endcase
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    elem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HRUN) |-> (elem_w < vl_q));

    // R5
    vl_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_q.vf) |-> (vl_out <= vl_q));

    // R8
    vf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_q.vf) |-> ((vl_out == elem_w) || (vl_out == elem_w + VLW'(1))));

    // R6
    rec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (cfg_q.rec && busy));

    // R2
    empty_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !cfg_in.vf && vec_len == '0)
            |=> (done && vl_out == '0 && taken == $past(!cfg_in.all_mode)));

endmodule

// File: rtl/vbrcond_eval.sv
module vbrcond_eval
    import vbr_pkg::*;
#(
    parameter int MAXVL      = 16,
    parameter int FIELDS     = 128,
    parameter int FW         = 4,
    parameter int REC_BIT_D  = 30,
    parameter int REC_BIT_L  = 16,
    localparam int AW        = $clog2(FIELDS),
    localparam int SW        = $clog2(FW),
    localparam int EW        = $clog2(MAXVL),
    localparam int VLW       = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vec_len,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic [AW+SW-1:0] bit_sel,
    input  logic             expect_val,
    input  logic             all_mode,
    input  logic [31:0]      instr_word,
    input  logic             lr_form,
    input  logic             vert_first,
    input  logic             step_mode,
    input  logic [FW-1:0]    step_bits,
    input  logic [EW-1:0]    src_step,
    input  logic             ld_we,
    input  logic [AW-1:0]    ld_idx,
    input  logic [FW-1:0]    ld_data,
    input  logic [AW-1:0]    pk_idx,
    output logic [FW-1:0]    pk_data,
    output logic             busy,
    output logic             done,
    output logic             taken,
    output logic [VLW-1:0]   vl_out,
    output logic             step_we,
    output logic [VLW-1:0]   step_val
);

    vbr_cfg_t      cfg_in, cfg_q;
    logic          rec_dec;
    logic [AW-1:0] rd_field, eng_waddr, f_waddr;
    logic [FW-1:0] rd_bits, el_bits, f_wdata;
    logic          eng_we, f_we;
    logic          el_ok, stop_hit;
    logic [SW-1:0] sel_q;

    assign rec_dec = lr_form ? instr_word[REC_BIT_L] : instr_word[REC_BIT_D];

    always_comb begin
        cfg_in.all_mode  = all_mode;
        cfg_in.rec       = rec_dec;
        cfg_in.expect_v  = expect_val;
        cfg_in.vf        = vert_first;
        cfg_in.step_mode = step_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sel_q <= '0;
        else if (start && !busy) sel_q <= bit_sel[SW-1:0];
    end

    assign el_bits = cfg_q.step_mode ? step_bits : rd_bits;
    assign f_we    = busy ? eng_we : ld_we;
    assign f_waddr = busy ? eng_waddr : ld_idx;
    assign f_wdata = busy ? el_bits : ld_data;

    vbr_cf_file #(.FIELDS(FIELDS), .FW(FW)) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (f_we),
        .waddr (f_waddr),
        .wdata (f_wdata),
        .raddr (rd_field),
        .rdata (rd_bits),
        .paddr (pk_idx),
        .pdata (pk_data)
    );

    vbr_elem_test #(.FW(FW)) u_test (
        .bits     (el_bits),
        .sel      (sel_q),
        .expect_v (cfg_q.expect_v),
        .all_mode (cfg_q.all_mode),
        .el_ok    (el_ok),
        .stop_hit (stop_hit)
    );

    vbr_seq #(.MAXVL(MAXVL), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vec_len    (vec_len),
        .pred_mask  (pred_mask),
        .base_field (bit_sel[AW+SW-1:SW]),
        .src_step   (src_step),
        .cfg_in     (cfg_in),
        .el_ok      (el_ok),
        .stop_hit   (stop_hit),
        .cfg_o      (cfg_q),
        .rd_field   (rd_field),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .busy       (busy),
        .done       (done),
        .taken      (taken),
        .vl_out     (vl_out),
        .step_we    (step_we),
        .step_val   (step_val)
    );

    // R10
    load_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_we && !eng_we) |=> $stable(u_file.mem_q[$past(ld_idx)]));

endmodule

// File: tb/vbrcond_eval_test.sv
module vbrcond_eval_test;

    localparam int MAXVL = 16;
    localparam int VLW   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  vec_len = '0;
    logic [15:0] pred_mask = '0;
    logic [8:0]  bit_sel = '0;
    logic        expect_val = 1'b0;
    logic        all_mode = 1'b0;
    logic [31:0] instr_word = '0;
    logic        lr_form = 1'b0;
    logic        vert_first = 1'b0;
    logic        step_mode = 1'b0;
    logic [3:0]  step_bits = '0;
    logic [3:0]  src_step = '0;
    logic        ld_we = 1'b0;
    logic [6:0]  ld_idx = '0;
    logic [3:0]  ld_data = '0;
    logic [6:0]  pk_idx = '0;
    logic [3:0]  pk_data;
    logic        busy, done, taken, step_we;
    logic [4:0]  vl_out, step_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [3:0] mdl [128];

    always #2 clk = ~clk;

    vbrcond_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .pred_mask(pred_mask), .bit_sel(bit_sel), .expect_val(expect_val),
        .all_mode(all_mode), .instr_word(instr_word), .lr_form(lr_form),
        .vert_first(vert_first), .step_mode(step_mode), .step_bits(step_bits),
        .src_step(src_step), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .pk_idx(pk_idx), .pk_data(pk_data), .busy(busy), .done(done),
        .taken(taken), .vl_out(vl_out), .step_we(step_we), .step_val(step_val)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_file(input int seed);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_idx  = 7'(i);
            ld_data = 4'((i * 7 + seed * 3 + (i >> 3)) & 15);
            mdl[i]  = ld_data;
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic cmp_file(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 128; i++) begin
            pk_idx = 7'(i);
            #0.1;
            if (pk_data !== mdl[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, tag, bad, 0);
        @(negedge clk);
    endtask

    task automatic run_case(input bit am, input bit rcw, input bit lrf, input bit vf,
                            input bit sm, input logic [3:0] sb, input logic [4:0] vl,
                            input logic [15:0] pm, input logic [8:0] bs, input bit ex,
                            input logic [3:0] ss);
        bit   res;
        int   vle, visited, steps, lastv, lat, got_steps, got_last;
        logic [3:0] bits;
        logic [6:0] fld;
        bit   el;
        res = !am; vle = vl; visited = 0; steps = 0; lastv = 0;
        if (vf) begin
            visited = 1;
            if (pm[ss]) begin
                fld  = 7'(bs[8:2] + 7'(ss));
                bits = sm ? sb : mdl[fld];
                if (rcw) mdl[ss] = bits;
                res  = (bits[bs[1:0]] == ex);
                vle  = ss + 1;
            end else begin
                vle = ss;
            end
            if (sm) begin steps = 1; lastv = ss + 1; end
        end else begin
            for (int k = 0; k < vl; k++) begin
                visited++;
                if (!pm[k]) begin vle = k; break; end
                fld  = 7'(bs[8:2] + 7'(k));
                bits = sm ? sb : mdl[fld];
                if (rcw) mdl[k] = bits;
                el   = (bits[bs[1:0]] == ex);
                res  = el;
                if (sm) begin steps++; lastv = k + 1; end
                if (am ? !el : el) break;
            end
        end
        @(negedge clk);
        all_mode = am; vert_first = vf; step_mode = sm; step_bits = sb;
        vec_len = vl; pred_mask = pm; bit_sel = bs; expect_val = ex; src_step = ss;
        lr_form = lrf;
        instr_word = '0;
        instr_word[lrf ? 16 : 30] = rcw;
        instr_word[lrf ? 30 : 16] = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1; got_steps = 0; got_last = 0;
        while (!done && lat < 60) begin
            if (step_we) begin got_steps++; got_last = step_val; end
            @(negedge clk);
            lat++;
        end
        chk(done === 1'b1, "R7 done seen", int'(done), 1);
        chk(lat == visited + 1, vf ? "R8 latency" : "R7 latency", lat, visited + 1);
        chk(taken === res, vf ? "R8 taken" : (vl == 0 ? "R2 taken" : "R3 R4 R5 taken"),
            int'(taken), int'(res));
        chk(int'(vl_out) == vle, vf ? "R8 vl_out" : "R2 R4 R5 vl_out", vl_out, vle);
        chk(got_steps == steps && got_last == lastv, "R9 step strobes",
            got_steps * 100 + got_last, steps * 100 + lastv);
        @(negedge clk);
        chk(done === 1'b0, "R7 done width", int'(done), 0);
        cmp_file("R6 R1 field file");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pms [4];
        logic [4:0]  vls [5];
        logic [8:0]  bss [3];
        int run;
        pms[0] = 16'hFFFF; pms[1] = 16'hFFF7; pms[2] = 16'hFFFE; pms[3] = 16'h7FFF;
        vls[0] = 5'd0; vls[1] = 5'd1; vls[2] = 5'd2; vls[3] = 5'd5; vls[4] = 5'd16;
        bss[0] = 9'h002; bss[1] = 9'h1F7; bss[2] = 9'h0A1;
        for (int i = 0; i < 128; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && taken === 1'b0 && vl_out === '0,
            "R7 reset state", int'({busy, done, taken}), 0);
        rst_n = 1'b1;
        cmp_file("R10 reset file");
        run = 0;
        for (int a = 0; a < 2; a++)
            for (int r = 0; r < 2; r++)
                for (int v = 0; v < 5; v++)
                    for (int p = 0; p < 4; p++)
                        for (int e = 0; e < 2; e++)
                            for (int b = 0; b < 3; b++) begin
                                if (run % 24 == 0) load_file(run);
                                run_case(a[0], r[0], run[0], 1'b0, 1'b0, 4'h0, vls[v],
                                         pms[p], bss[b], e[0], 4'h0);
                                run++;
                            end
        // R9 horizontal with stepping unit bits
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 2; p++)
                    run_case(a[0], 1'b1, p[0], 1'b0, 1'b1, s[0] ? 4'hA : 4'h5, 5'd16,
                             p[0] ? 16'hFFEF : 16'hFFFF, 9'h013, 1'b1, 4'h0);
        // R8 vertical-first sweep
        load_file(7);
        for (int s = 0; s < 16; s++)
            for (int p = 0; p < 2; p++)
                for (int r = 0; r < 2; r++)
                    for (int m = 0; m < 2; m++)
                        run_case(s[0], r[0], m[0], 1'b1, m[0], 4'h6, 5'd3,
                                 p[0] ? 16'(1 << s) : ~16'(1 << s), 9'h0C6, 1'b1, 4'(s));
        // R10 load blocked while busy, accepted while idle
        @(negedge clk);
        all_mode = 1'b1; vert_first = 1'b0; step_mode = 1'b1; step_bits = 4'hF;
        expect_val = 1'b1; bit_sel = 9'h000; vec_len = 5'd16; pred_mask = 16'hFFFF;
        lr_form = 1'b0; instr_word = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ld_we = 1'b1; ld_idx = 7'd100; ld_data = ~mdl[100];
        @(negedge clk);
        ld_we = 1'b0;
        chk(busy === 1'b1, "R10 busy during load", int'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        pk_idx = 7'd100; #0.1;
        chk(pk_data === mdl[100], "R10 load ignored while busy", pk_data, mdl[100]);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = 7'd100; ld_data = 4'h5;
        @(negedge clk);
        ld_we = 1'b0; mdl[100] = 4'h5;
        pk_idx = 7'd100; #0.1;
        chk(pk_data === 4'h5, "R10 load while idle", pk_data, 5);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule